// File: doc/BRIEF.md
# Overlapped Fetch-Execute Micro Core

This block is a very small processor core built around 8-bit registers and a 16-bit memory port. Every active cycle it reads one 16-bit instruction word from a byte address formed from an 8-bit segment register and an 8-bit instruction pointer. It then moves the pointer on by one word. The word read in one cycle is executed in the following cycle, so fetch and execute overlap. The only instruction it decodes is a load of an 8-bit immediate into register zero. An instruction of that kind has a zero opcode byte, and its low byte is the value loaded.

A second bus master can claim the memory port through a request/grant pair. The core registers the request and acknowledges it on the next edge. While the grant is up, the core freezes all of its state and releases its address, write data, write-enable and word-strobe outputs to high impedance. Debug taps expose the instruction register, the pointer, the segment, a test flag and register zero. A synchronous reset restores the start state in one edge, and reset wins over a bus request.

Top module: `mini_fetch_core`

## Requirements
- R1: On any clock edge with `rst` high, the core enters its start state: segment 0x01, pointer 0x00, instruction register 0x0000, register zero 0x00, test flag 0, and grant low.
- R2: In the first cycle after reset is released, `mem_addr` is 0x0100, which is the segment in bits 15:8 and the pointer in bits 7:0.
- R3: Each edge on which the core steps latches `mem_rdata` into the instruction register and adds 2 to the pointer, so the second fetch address is 0x0102.
- R4: The first step after reset executes nothing, and register zero keeps its reset value.
- R5: On a step, when the held instruction came from an earlier step and its bits 15:8 are 0x00, its bits 7:0 are written to register zero. Any other opcode byte leaves register zero unchanged.
- R6: With `hold_req` high at an edge, `hold_ack` is high after that edge. No step occurs on an edge where `hold_req` or `hold_ack` is high, so the pointer, segment, instruction register and register zero all stay unchanged.
- R7: While `hold_ack` is high, `mem_addr`, `mem_wdata`, `mem_wr_en` and `mem_word_wr` are high impedance, and another master can drive the address lines.
- R8: With `hold_req` low at an edge, `hold_ack` is low after that edge. The next edge resumes fetching at the address that was frozen.
- R9: A reset edge with `hold_req` high still leaves `hold_ack` low and the start state of R1.
- R10: Outside a hold, `mem_wr_en` and `mem_word_wr` are 0, because fetching and loading never write memory.
- R11: The pointer wraps from 0xFE to 0x00 within 8 bits, and the segment does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Request from another master for the memory port |
| hold_ack | output | 1 | Grant; the core is paused and its bus outputs are released |
| mem_addr | output | 16 | Byte address of the fetch; high-Z while granted |
| mem_rdata | input | 16 | Instruction word read from memory |
| mem_wdata | output | 16 | Write data (idle 0); high-Z while granted |
| mem_wr_en | output | 1 | Write enable (idle 0); high-Z while granted |
| mem_word_wr | output | 1 | 16-bit versus byte write strobe (idle 0); high-Z while granted |
| dbg_ir | output | 16 | Instruction register |
| dbg_ip | output | 8 | Instruction pointer |
| dbg_cs | output | 8 | Code segment |
| dbg_tr | output | 1 | Test flag |
| dbg_r0 | output | 8 | Register zero |

## Verification
Two things can meet on the same edge. One is a bus request arriving just as a load-immediate instruction is due to execute. The other is a reset arriving while a request is held. The bench raises `hold_req` straight after a load word has been latched, and it toggles the request for single cycles. It then checks that register zero, the pointer and the instruction register stay put until the grant falls, and that the pending load executes on the first edge after the resume. It also asserts reset together with the request and expects the grant to stay low and the start state to appear. A behavioural model predicts every output on every cycle.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

   typedef enum logic [0:0] {
      OPK_NONE    = 1'b0,
      OPK_LOAD_R0 = 1'b1
   } op_kind_e;

endpackage

// File: rtl/mfc_hold_ctrl.sv
module mfc_hold_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic hold_req,
   output logic hold_ack,
   output logic step_en
);

   logic ack_q;

   always_ff @(posedge clk) begin
      if (rst) ack_q <= 1'b0;
      else     ack_q <= hold_req;
   end

   assign hold_ack = ack_q;
   assign step_en  = !hold_req && !ack_q;

   AST_ACK_RISES: assert property (@(posedge clk) disable iff (rst)
      hold_req |=> hold_ack); // R6
   AST_ACK_FALLS: assert property (@(posedge clk) disable iff (rst)
      !hold_req |=> !hold_ack); // R8
   AST_RESET_WINS: assert property (@(posedge clk)
      $past(rst) |-> !hold_ack); // R9

endmodule

// File: rtl/mfc_fetch.sv
module mfc_fetch #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  RESET_CS = 8'h01,
   parameter logic [7:0]  RESET_IP = 8'h00,
   parameter int unsigned IP_STEP  = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic [DATA_W-1:0] rdata,
   output logic [REG_W-1:0]  cs,
   output logic [REG_W-1:0]  ip,
   output logic [DATA_W-1:0] ir,
   output logic              ir_valid
);

   localparam logic [REG_W-1:0] STEP_V = REG_W'(IP_STEP);

   logic [REG_W-1:0]  cs_q, ip_q;
   logic [DATA_W-1:0] ir_q;
   logic              valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cs_q    <= REG_W'(RESET_CS);
         ip_q    <= REG_W'(RESET_IP);
         ir_q    <= '0;
         valid_q <= 1'b0;
      end else if (step_en) begin
         ip_q    <= ip_q + STEP_V;
         ir_q    <= rdata;
         valid_q <= 1'b1;
      end
   end

   assign cs       = cs_q;
   assign ip       = ip_q;
   assign ir       = ir_q;
   assign ir_valid = valid_q;

   AST_IP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (ip_q == REG_W'($past(ip_q) + STEP_V))); // R3
   AST_IR_LATCH: assert property (@(posedge clk) disable iff (rst)
      step_en |=> (ir_q == $past(rdata))); // R3
   AST_FETCH_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(ip_q) && $stable(ir_q))); // R6
   AST_CS_STEADY: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> $stable(cs_q)); // R11
   AST_RESET_STATE: assert property (@(posedge clk)
      $past(rst) |-> (cs_q == REG_W'(RESET_CS) && ip_q == REG_W'(RESET_IP) && !valid_q)); // R1

endmodule

// File: rtl/mfc_exec.sv
module mfc_exec #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  OPC_LOAD = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_en,
   input  logic [DATA_W-1:0] ir,
   input  logic              ir_valid,
   output logic [REG_W-1:0]  r0,
   output logic              tr
);

   import mfc_pkg::*;

   localparam int unsigned OPC_W = DATA_W - REG_W;

   op_kind_e          kind;
   logic [REG_W-1:0]  r0_q;
   logic              tr_q;
   logic              fire;

   always_comb begin
      kind = OPK_NONE;
      if (ir[DATA_W-1:REG_W] == OPC_W'(OPC_LOAD)) kind = OPK_LOAD_R0;
   end

   assign fire = step_en && ir_valid && (kind == OPK_LOAD_R0);

   always_ff @(posedge clk) begin
      if (rst)       r0_q <= '0;
      else if (fire) r0_q <= ir[REG_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (rst) tr_q <= 1'b0;
      else     tr_q <= tr_q;
   end

   assign r0 = r0_q;
   assign tr = tr_q;

   AST_R0_KEEP: assert property (@(posedge clk) disable iff (rst)
      (!step_en || !ir_valid) |=> $stable(r0_q)); // R4
   AST_R0_LOAD: assert property (@(posedge clk) disable iff (rst)
      fire |=> (r0_q == $past(ir[REG_W-1:0]))); // R5
   AST_TR_CLEAR: assert property (@(posedge clk)
      $past(rst) |-> (!tr_q && r0_q == '0)); // R1

endmodule

// File: rtl/mfc_bus_drv.sv
module mfc_bus_drv #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned DATA_W   = 16,
   parameter bit          TRISTATE = 1'b1
) (
   input  logic              released,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              we_in,
   input  logic              ww_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wr_en,
   output logic              mem_word_wr
);

   generate
      if (TRISTATE) begin : g_tri
         assign mem_addr    = released ? {ADDR_W{1'bz}} : addr_in;
         assign mem_wdata   = released ? {DATA_W{1'bz}} : wdata_in;
         assign mem_wr_en   = released ? 1'bz : we_in;
         assign mem_word_wr = released ? 1'bz : ww_in;
      end else begin : g_idle
         assign mem_addr    = released ? '0 : addr_in;
         assign mem_wdata   = released ? '0 : wdata_in;
         assign mem_wr_en   = released ? 1'b0 : we_in;
         assign mem_word_wr = released ? 1'b0 : ww_in;
      end
   endgenerate

endmodule

// File: rtl/mini_fetch_core.sv
module mini_fetch_core #(
   parameter int unsigned REG_W    = 8,
   parameter int unsigned DATA_W   = 16,
   parameter logic [7:0]  RESET_CS = 8'h01,
   parameter logic [7:0]  RESET_IP = 8'h00,
   parameter int unsigned IP_STEP  = 2,
   parameter logic [7:0]  OPC_LOAD = 8'h00,
   parameter bit          TRISTATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              hold_req,
   output logic              hold_ack,
   output logic [2*REG_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_wr_en,
   output logic              mem_word_wr,
   output logic [DATA_W-1:0] dbg_ir,
   output logic [REG_W-1:0]  dbg_ip,
   output logic [REG_W-1:0]  dbg_cs,
   output logic              dbg_tr,
   output logic [REG_W-1:0]  dbg_r0
);

   localparam int unsigned ADDR_W = 2 * REG_W;

   initial begin
      if (DATA_W != 2 * REG_W)
         $error("mini_fetch_core: DATA_W must be twice REG_W");
      if (IP_STEP != DATA_W / 8)
         $error("mini_fetch_core: IP_STEP must equal bytes per word");
      if (REG_W < 8)
         $error("mini_fetch_core: REG_W must be at least 8");
   end

   logic              step_en, ack;
   logic [REG_W-1:0]  cs, ip, r0;
   logic [DATA_W-1:0] ir;
   logic              ir_valid, tr;

   mfc_hold_ctrl u_hold (
      .clk(clk), .rst(rst), .hold_req(hold_req),
      .hold_ack(ack), .step_en(step_en)
   );

   mfc_fetch #(
      .REG_W(REG_W), .DATA_W(DATA_W), .RESET_CS(RESET_CS),
      .RESET_IP(RESET_IP), .IP_STEP(IP_STEP)
   ) u_fetch (
      .clk(clk), .rst(rst), .step_en(step_en), .rdata(mem_rdata),
      .cs(cs), .ip(ip), .ir(ir), .ir_valid(ir_valid)
   );

   mfc_exec #(
      .REG_W(REG_W), .DATA_W(DATA_W), .OPC_LOAD(OPC_LOAD)
   ) u_exec (
      .clk(clk), .rst(rst), .step_en(step_en), .ir(ir),
      .ir_valid(ir_valid), .r0(r0), .tr(tr)
   );

   mfc_bus_drv #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRISTATE(TRISTATE)
   ) u_bus (
      .released(ack), .addr_in({cs, ip}), .wdata_in('0),
      .we_in(1'b0), .ww_in(1'b0),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_wr_en(mem_wr_en), .mem_word_wr(mem_word_wr)
   );

   assign hold_ack = ack;
   assign dbg_ir   = ir;
   assign dbg_ip   = ip;
   assign dbg_cs   = cs;
   assign dbg_tr   = tr;
   assign dbg_r0   = r0;

   AST_PAUSE_KEEPS_R0: assert property (@(posedge clk) disable iff (rst)
      ack |=> $stable(r0)); // R6

endmodule

// File: tb/mini_fetch_core_tb.sv
module mini_fetch_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        hold_req = 1'b0;
   logic [15:0] mem_rdata = 16'h0000;
   logic        hold_ack;
   wire  [15:0] mem_addr;
   wire  [15:0] mem_wdata;
   wire         mem_wr_en;
   wire         mem_word_wr;
   logic [15:0] dbg_ir;
   logic [7:0]  dbg_ip, dbg_cs, dbg_r0;
   logic        dbg_tr;

   // second bus master, active only while the core grants the port
   logic        tb_own = 1'b0;
   logic [15:0] tb_addr = 16'h0000;
   assign mem_addr = tb_own ? tb_addr : 16'hzzzz;

   always #2 clk = ~clk;

   mini_fetch_core u_dut (
      .clk(clk), .rst(rst), .hold_req(hold_req), .hold_ack(hold_ack),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
      .mem_wr_en(mem_wr_en), .mem_word_wr(mem_word_wr),
      .dbg_ir(dbg_ir), .dbg_ip(dbg_ip), .dbg_cs(dbg_cs),
      .dbg_tr(dbg_tr), .dbg_r0(dbg_r0)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int m_cs, m_ip, m_ir, m_r0, m_tr, m_ack, m_valid;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int ack_next;
      if (rst) begin
         m_cs = 1; m_ip = 0; m_ir = 0; m_r0 = 0; m_tr = 0; m_ack = 0; m_valid = 0;
      end else begin
         ack_next = hold_req;
         if (!hold_req && m_ack == 0) begin
            if (m_valid == 1 && (m_ir >> 8) == 0) m_r0 = m_ir & 'hFF;
            m_ir = mem_rdata;
            m_ip = (m_ip + 2) % 256;
            m_valid = 1;
         end
         m_ack = ack_next;
      end
   endtask

   task automatic compare();
      chk(hold_ack == m_ack[0], "R6/R8/R9 grant", hold_ack, m_ack);
      chk(dbg_ip == 8'(m_ip), m_ack ? "R6 pointer frozen" : "R3/R11 pointer", dbg_ip, m_ip);
      chk(dbg_cs == 8'(m_cs), "R1/R11 segment", dbg_cs, m_cs);
      chk(dbg_ir == 16'(m_ir), m_ack ? "R6 ir frozen" : "R3 ir", dbg_ir, m_ir);
      chk(dbg_r0 == 8'(m_r0), "R4/R5 r0", dbg_r0, m_r0);
      chk(dbg_tr == m_tr[0], "R1 test flag", dbg_tr, m_tr);
      if (m_ack != 0) begin
         tb_addr = 16'hA5C3 ^ 16'(checks);
         tb_own = 1'b1;
         #1;
         chk(mem_addr == tb_addr, "R7 released address", mem_addr, tb_addr);
      end else begin
         tb_own = 1'b0;
         #1;
         chk(mem_addr == 16'((m_cs << 8) | m_ip), "R2/R3 fetch address",
             mem_addr, (m_cs << 8) | m_ip);
         chk(mem_wr_en == 1'b0 && mem_word_wr == 1'b0, "R10 no write",
             {mem_wr_en, mem_word_wr}, 0);
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare();
   endtask

   function automatic logic [15:0] word_for(input int i);
      if (i % 3 == 2) return {8'(8'h40 + i), 8'(i)};
      return {8'h00, 8'(8'h10 + i * 7)};
   endfunction

   initial begin
      // R9: reset together with a bus request
      rst = 1'b1; hold_req = 1'b1;
      cycle(); cycle();
      hold_req = 1'b0;
      cycle();
      // R2/R3/R4: first fetches after release
      rst = 1'b0; mem_rdata = 16'h0012;
      cycle();
      chk(mem_addr == 16'h0102, "R3 second address", mem_addr, 16'h0102);
      chk(dbg_r0 == 8'h00, "R4 nothing executed on first step", dbg_r0, 0);
      mem_rdata = 16'h00F1;
      cycle();
      chk(dbg_r0 == 8'h12, "R5 first load", dbg_r0, 8'h12);
      mem_rdata = 16'h1234;
      cycle();
      chk(dbg_r0 == 8'hF1, "R5 second load", dbg_r0, 8'hF1);
      mem_rdata = 16'h0056;
      cycle();
      chk(dbg_r0 == 8'hF1, "R5 non-load opcode ignored", dbg_r0, 8'hF1);
      // request right after a load word was latched: load must wait
      mem_rdata = 16'h0077;
      hold_req = 1'b1;
      for (int i = 0; i < 4; i++) cycle();
      chk(dbg_r0 == 8'hF1, "R6 pending load held", dbg_r0, 8'hF1);
      hold_req = 1'b0;
      cycle();
      hold_req = 1'b1;
      cycle();
      hold_req = 1'b0;
      cycle(); cycle();
      // long run to wrap the pointer
      for (int i = 0; i < 140; i++) begin
         mem_rdata = word_for(i);
         cycle();
      end
      // reset mid-run with a request up
      rst = 1'b1; hold_req = 1'b1;
      cycle(); cycle();
      rst = 1'b0; hold_req = 1'b0; mem_rdata = 16'h00C4;
      for (int i = 0; i < 5; i++) begin
         cycle();
         mem_rdata = word_for(i + 7);
      end
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #800000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule